// File: doc/BRIEF.md
# Compensated Nanosecond Time Counter

This block keeps a 64-bit time of day in nanoseconds. On every reference clock cycle in which counting is enabled it adds a small programmable step (the nominal clock period in ns) to the count. The rate can be trimmed in two ways, and both work by replacing the nominal step with an alternate "trim" step on selected cycles. A periodic trim fires once every S enabled cycles, and a burst trim applies the trim step to the next F enabled cycles. Software can preload the count, read it without tearing across the two 32-bit halves, and watch a sticky wrap-around flag. A cycle mode returns the count to zero each time it equals a programmed compare value, so the counter runs as a fixed-length cycle timer.

Configuration and status use a single-cycle 32-bit register port. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr`, and the read side effect happens at the edge on which `reg_rd` is high. The port never stalls, so it has no back-pressure. The live count is also driven on `time_ns` for local consumers.

Register word indices: 0 control, 1 status, 2 burst trim, 3 periodic trim, 4 count low, 5 count high, 6 compare control, 7 compare low, 8 compare high. Other indices read as zero and ignore writes.

Top module: `nstime_counter`

## Requirements
- R1: After reset the count, control word (index 0), status word (index 1) and all trim and compare settings are zero, and counting is disabled.
- R2: Control word bit 0 enables counting, and bits 7:4 hold the nominal step. While enabled, each clock edge adds that step to the count. While disabled, the count holds.
- R3: A write to index 5 only stages the upper half. A write to index 4 loads {staged upper, written lower} into the count at that edge, and the load takes priority over that edge's step.
- R4: Index 3 holds a periodic trim interval S (a write also restarts its phase). When S is nonzero, every S-th enabled cycle adds the trim step from control bits 19:8 instead of the nominal step. When S is 0, periodic trimming is off.
- R5: Writing F to index 2 (24 bits) makes the next F enabled cycles use the trim step. F = 0 means no burst trim. Reading index 2 returns the cycles still remaining.
- R6: When burst and periodic trim select the same cycle, the trim step is added once, not twice.
- R7: Reading index 4 latches the current upper half, and a later read of index 5 returns that latched value even if the count has since carried.
- R8: A carry out of bit 63 sets status bit 0. The bit stays set until 1 is written to it; writing 0 has no effect; a new carry wins over a clear on the same edge.
- R9: Compare control (index 6) bit 0 enables reset-on-match and bit 1 enables compare. With both set, an enabled edge at which the count equals the 64-bit compare value (indices 7 and 8) loads zero instead of stepping. With either bit clear, no wrap occurs.
- R10: Control, periodic trim, compare control and compare registers read back as written, limited to their defined fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers the upper-half latch) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| time_ns | output | 64 | Live count in nanoseconds |

## Verification
The bench builds the block with its default parameters: a 32-bit register word, a 24-bit burst trim count and a 32-bit periodic interval. With these values a full 64-bit count can be preloaded, so a carry across the word boundary and the wrap past bit 63 each take only a few cycles. The largest trim step (4095) and the largest nominal step (15) are also exercised. Short intervals and short bursts make trims coincide within a handful of cycles, and a small compare value makes cycle-mode wraps happen early in a run.

// File: rtl/nstc_pkg.sv
package nstc_pkg;
  typedef enum logic [3:0] {
    A_CTRL    = 4'd0,
    A_STAT    = 4'd1,
    A_BURST   = 4'd2,
    A_PERIOD  = 4'd3,
    A_CNT_LO  = 4'd4,
    A_CNT_HI  = 4'd5,
    A_CMPCTL  = 4'd6,
    A_CMP_LO  = 4'd7,
    A_CMP_HI  = 4'd8
  } reg_idx_e;

  localparam int EN_BIT   = 0;
  localparam int STEP_LSB = 4;
  localparam int STEP_W   = 4;
  localparam int TRIM_LSB = 8;
  localparam int TRIM_W   = 12;
endpackage

// File: rtl/nstc_regs.sv
module nstc_regs
  import nstc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BURST_W = 24,
  parameter int PER_W   = 32,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [3:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               carry_evt,
  input  logic [BURST_W-1:0] burst_left,
  output logic               run_en,
  output logic [STEP_W-1:0]  step,
  output logic [TRIM_W-1:0]  trim,
  output logic               cnt_load,
  output logic [CNT_W-1:0]   cnt_load_val,
  output logic               burst_load,
  output logic               per_load,
  output logic [PER_W-1:0]   per_val,
  output logic               wrap_en,
  output logic [CNT_W-1:0]   cmp_val
);
  reg_idx_e           idx;
  logic [DATA_W-1:0]  stage_hi, snap_hi;
  logic               wrap_q, cmp_on_q, flag_q;
  logic               clr_req;

  assign idx          = reg_idx_e'(addr);
  assign cnt_load     = wr && (idx == A_CNT_LO);
  assign cnt_load_val = {stage_hi, wdata};
  assign burst_load   = wr && (idx == A_BURST);
  assign wrap_en      = wrap_q && cmp_on_q;
  assign clr_req      = wr && (idx == A_STAT) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      step     <= '0;
      trim     <= '0;
      per_val  <= '0;
      stage_hi <= '0;
      snap_hi  <= '0;
      wrap_q   <= 1'b0;
      cmp_on_q <= 1'b0;
      cmp_val  <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr) begin
        case (idx)
          A_CTRL: begin
            run_en <= wdata[EN_BIT];
            step   <= wdata[STEP_LSB +: STEP_W];
            trim   <= wdata[TRIM_LSB +: TRIM_W];
          end
          A_PERIOD: per_val  <= wdata[PER_W-1:0];
          A_CNT_HI: stage_hi <= wdata;
          A_CMPCTL: begin
            wrap_q   <= wdata[0];
            cmp_on_q <= wdata[1];
          end
          A_CMP_LO: cmp_val[DATA_W-1:0]     <= wdata;
          A_CMP_HI: cmp_val[CNT_W-1:DATA_W] <= wdata;
          default: ;
        endcase
      end
      if (rd && (idx == A_CNT_LO)) snap_hi <= cnt[CNT_W-1:DATA_W];
      if (carry_evt)    flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  assign per_load = wr && (idx == A_PERIOD);

  always_comb begin
    rdata = '0;
    case (idx)
      A_CTRL: begin
        rdata[EN_BIT]               = run_en;
        rdata[STEP_LSB +: STEP_W]   = step;
        rdata[TRIM_LSB +: TRIM_W]   = trim;
      end
      A_STAT:   rdata[0] = flag_q;
      A_BURST:  rdata = DATA_W'(burst_left);
      A_PERIOD: rdata = DATA_W'(per_val);
      A_CNT_LO: rdata = cnt[DATA_W-1:0];
      A_CNT_HI: rdata = snap_hi;
      A_CMPCTL: rdata[1:0] = {cmp_on_q, wrap_q};
      A_CMP_LO: rdata = cmp_val[DATA_W-1:0];
      A_CMP_HI: rdata = cmp_val[CNT_W-1:DATA_W];
      default:  rdata = '0;
    endcase
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    carry_evt |=> flag_q);
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);
  p_hi_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (idx == A_CNT_LO)) |=> (snap_hi == $past(cnt[CNT_W-1:DATA_W])));
endmodule

// File: rtl/nstc_trim.sv
module nstc_trim #(
  parameter int BURST_W = 24,
  parameter int PER_W   = 32,
  parameter int STEP_W  = 4,
  parameter int TRIM_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [STEP_W-1:0]  step,
  input  logic [TRIM_W-1:0]  trim,
  input  logic               burst_load,
  input  logic [BURST_W-1:0] burst_val,
  input  logic               per_load,
  input  logic [PER_W-1:0]   per_new,
  input  logic [PER_W-1:0]   per_val,
  output logic [TRIM_W-1:0]  inc,
  output logic [BURST_W-1:0] burst_left
);
  logic [PER_W-1:0] per_cnt;
  logic             burst_fire, per_fire, use_trim;

  assign burst_fire = (burst_left != '0);
  assign per_fire   = (per_val != '0) && (per_cnt <= PER_W'(1));
  assign use_trim   = burst_fire || per_fire;
  assign inc        = use_trim ? trim : {{(TRIM_W-STEP_W){1'b0}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_left <= '0;
      per_cnt    <= '0;
    end else begin
      if (burst_load)               burst_left <= burst_val;
      else if (tick && burst_fire)  burst_left <= burst_left - BURST_W'(1);

      if (per_load)                 per_cnt <= per_new;
      else if (tick && per_val != '0) begin
        if (per_fire) per_cnt <= per_val;
        else          per_cnt <= per_cnt - PER_W'(1);
      end
    end
  end

  p_burst_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !burst_load && burst_left != '0) |=> (burst_left == $past(burst_left) - BURST_W'(1)));
  p_burst_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !burst_load) |=> $stable(burst_left));
  p_per_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !per_load && per_fire) |=> (per_cnt == $past(per_val)));
endmodule

// File: rtl/nstc_core.sv
module nstc_core #(
  parameter int CNT_W = 64,
  parameter int INC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             wrap_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             carry_evt
);
  logic [CNT_W:0] sum;
  logic           hit;

  assign sum       = {1'b0, cnt} + (CNT_W+1)'(inc);
  assign hit       = wrap_en && (cnt == cmp_val);
  assign carry_evt = en && !load && !hit && sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (en) begin
      if (hit) cnt <= '0;
      else     cnt <= sum[CNT_W-1:0];
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && hit) |=> (cnt == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !hit) |=> (cnt == $past(cnt) + CNT_W'($past(inc))));
endmodule

// File: rtl/nstime_counter.sv
module nstime_counter
  import nstc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BURST_W = 24,
  parameter int PER_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [2*DATA_W-1:0] time_ns
);
  localparam int CNT_W = 2 * DATA_W;

  logic               run_en, cnt_load, burst_load, per_load, wrap_en, carry_evt;
  logic [STEP_W-1:0]  step;
  logic [TRIM_W-1:0]  trim, inc;
  logic [CNT_W-1:0]   cnt_load_val, cmp_val, cnt;
  logic [PER_W-1:0]   per_val;
  logic [BURST_W-1:0] burst_left;

  nstc_regs #(.DATA_W(DATA_W), .BURST_W(BURST_W), .PER_W(PER_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cnt(cnt), .carry_evt(carry_evt),
    .burst_left(burst_left), .run_en(run_en), .step(step), .trim(trim),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .burst_load(burst_load),
    .per_load(per_load), .per_val(per_val), .wrap_en(wrap_en), .cmp_val(cmp_val)
  );

  nstc_trim #(.BURST_W(BURST_W), .PER_W(PER_W), .STEP_W(STEP_W), .TRIM_W(TRIM_W)) trim_i (
    .clk(clk), .rst_n(rst_n), .tick(run_en), .step(step), .trim(trim),
    .burst_load(burst_load), .burst_val(reg_wdata[BURST_W-1:0]),
    .per_load(per_load), .per_new(reg_wdata[PER_W-1:0]), .per_val(per_val),
    .inc(inc), .burst_left(burst_left)
  );

  nstc_core #(.CNT_W(CNT_W), .INC_W(TRIM_W)) core_i (
    .clk(clk), .rst_n(rst_n), .en(run_en), .inc(inc), .load(cnt_load),
    .load_val(cnt_load_val), .wrap_en(wrap_en), .cmp_val(cmp_val),
    .cnt(cnt), .carry_evt(carry_evt)
  );

  assign time_ns = cnt;
endmodule

// File: tb/nstime_counter_tb_top.sv
module nstime_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_ns;

  int n_run = 0, n_bad = 0;
  bit done = 1'b0;

  nstime_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_ns(time_ns)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  stp;
    logic [11:0] trm;
    logic [23:0] burst;
    logic [31:0] per;
    logic [15:0] n;
    logic [63:0] start;
    logic [63:0] expv;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{stp:4'd5,  trm:12'd7,    burst:24'd0, per:32'd0, n:16'd10, start:64'd0,            expv:64'h32},
    '{stp:4'd4,  trm:12'd6,    burst:24'd0, per:32'd4, n:16'd12, start:64'd1000,         expv:64'h41E},
    '{stp:4'd10, trm:12'd3,    burst:24'd5, per:32'd0, n:16'd8,  start:64'h1_0000_0000,  expv:64'h1_0000_002D},
    '{stp:4'd3,  trm:12'd5,    burst:24'd3, per:32'd3, n:16'd6,  start:64'd0,            expv:64'h1A},
    '{stp:4'd15, trm:12'd4095, burst:24'd0, per:32'd1, n:16'd4,  start:64'hFFFF_FFF0,    expv:64'h1_0000_3FEC}
  };

  function automatic logic [31:0] ctl(input bit en, input logic [3:0] s, input logic [11:0] t);
    return {12'd0, t, s, 3'd0, en};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_cnt(input logic [63:0] v);
    wr(4'd5, v[63:32]);
    wr(4'd4, v[31:0]);
  endtask

  task automatic run_ticks(input logic [31:0] cfg_off, input int n);
    wr(4'd0, cfg_off | 32'd1);
    repeat (n - 1) @(negedge clk);
    wr(4'd0, cfg_off);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, lo_seen;
    logic [63:0] t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 count", time_ns, 64'd0);
    rd(4'd0, d); check("R1 control", {32'd0, d}, 64'd0);
    rd(4'd1, d); check("R1 status", {32'd0, d}, 64'd0);

    // Vector table: R2 R4 R5 R6
    for (int i = 0; i < 5; i++) begin
      wr(4'd0, ctl(1'b0, VECS[i].stp, VECS[i].trm));
      wr(4'd2, {8'd0, VECS[i].burst});
      wr(4'd3, VECS[i].per);
      set_cnt(VECS[i].start);
      run_ticks(ctl(1'b0, VECS[i].stp, VECS[i].trm), int'(VECS[i].n));
      check($sformatf("R2/R4/R5/R6 vec%0d time", i), time_ns, VECS[i].expv);
      rd(4'd4, d); check($sformatf("R7 vec%0d lo", i), {32'd0, d}, {32'd0, VECS[i].expv[31:0]});
      rd(4'd5, d); check($sformatf("R7 vec%0d hi", i), {32'd0, d}, {32'd0, VECS[i].expv[63:32]});
    end

    // R10 readback
    rd(4'd0, d); check("R10 control", {32'd0, d}, {32'd0, ctl(1'b0, 4'd15, 12'd4095)});
    rd(4'd3, d); check("R10 period", {32'd0, d}, 64'd1);
    wr(4'd3, 32'd0);

    // R2 hold while disabled
    t0 = time_ns;
    repeat (5) @(negedge clk);
    check("R2 hold", time_ns, t0);

    // R5 burst remaining readback: 4 of 6 left after 2 ticks
    wr(4'd0, ctl(1'b0, 4'd1, 12'd2));
    wr(4'd2, 32'd6);
    run_ticks(ctl(1'b0, 4'd1, 12'd2), 2);
    rd(4'd2, d); check("R5 burst left", {32'd0, d}, 64'd4);
    wr(4'd2, 32'd0);

    // R3 load wins over step while running
    wr(4'd0, ctl(1'b1, 4'd5, 12'd0));
    wr(4'd5, 32'h0000_ABCD);
    wr(4'd4, 32'h0000_1234);
    check("R3 load priority", time_ns, 64'h0000_ABCD_0000_1234);
    @(negedge clk);
    check("R3 step after load", time_ns, 64'h0000_ABCD_0000_1239);

    // R7 atomic read across a carry
    wr(4'd0, ctl(1'b0, 4'd5, 12'd0));
    set_cnt(64'h1_FFFF_FFF0);
    wr(4'd0, ctl(1'b1, 4'd5, 12'd0));
    t0 = time_ns;
    rd(4'd4, lo_seen);
    check("R7 low word", {32'd0, lo_seen}, {32'd0, t0[31:0]});
    repeat (8) @(negedge clk);
    check("R7 carry happened", {32'd0, time_ns[63:32]}, 64'd2);
    rd(4'd5, d); check("R7 latched high", {32'd0, d}, 64'd1);
    wr(4'd0, ctl(1'b0, 4'd5, 12'd0));

    // R8 overflow flag
    wr(4'd0, ctl(1'b0, 4'd4, 12'd0));
    set_cnt(64'hFFFF_FFFF_FFFF_FFFE);
    run_ticks(ctl(1'b0, 4'd4, 12'd0), 1);
    check("R8 wrapped value", time_ns, 64'd2);
    rd(4'd1, d); check("R8 flag set", {32'd0, d}, 64'd1);
    wr(4'd1, 32'd0);
    rd(4'd1, d); check("R8 write 0 keeps", {32'd0, d}, 64'd1);
    wr(4'd1, 32'd1);
    rd(4'd1, d); check("R8 write 1 clears", {32'd0, d}, 64'd0);

    // R9 cycle mode
    wr(4'd0, ctl(1'b0, 4'd5, 12'd0));
    wr(4'd7, 32'd95);
    wr(4'd8, 32'd0);
    wr(4'd6, 32'd3);
    rd(4'd6, d); check("R10 compare control", {32'd0, d}, 64'd3);
    set_cnt(64'd0);
    run_ticks(ctl(1'b0, 4'd5, 12'd0), 25);
    check("R9 wrap at compare", time_ns, 64'd25);
    rd(4'd1, d); check("R9 no flag on wrap", {32'd0, d}, 64'd0);
    wr(4'd6, 32'd1);
    set_cnt(64'd0);
    run_ticks(ctl(1'b0, 4'd5, 12'd0), 25);
    check("R9 compare disabled", time_ns, 64'd125);
    wr(4'd6, 32'd0);

    finish_run();
  end
endmodule